// File: doc/BRIEF.md
# Self-Test Word Pattern Checker

This block sits on the receive side of a serial link and checks the link during a self-test run. While self-test is enabled, the transmitter sends a constant all-zero payload. After clock recovery and descrambling, each recovered parallel word arrives here with a valid strobe. Any word that contains a set bit is a corrupted word.

The checker counts corrupted words in a saturating status count. It also drives a pass flag. During the run the flag follows the errors cycle by cycle, so a probe on the pin shows bursts of corruption as they happen. When self-test is switched off, the flag settles to a final verdict and the count freezes. Both then hold through normal traffic, so the result can be read later. Before the first run, the flag shows the result left by reset or by the previous run.

A run has four steps. The receiver is put into self-test first. The transmitter then follows, and the test runs for as long as needed. The receiver then returns to normal mode and the verdict is read. Finally both sides resume normal operation. Words are compared only while the receiver reports lock. A loss of lock pauses the comparison and does not disturb the count.

Top module: `bist_pattern_chk`

## Requirements
- R1: After reset the pass flag is 1 and the error count is 0.
- R2: In the first cycle that self-test is seen enabled (the entry cycle), the count and the run's error history are cleared and the pass flag becomes 1. The word presented in that cycle is not compared.
- R3: In every later cycle of the run where lock=1 and valid=1, a word with any bit set, including only the LSB or only the MSB, adds one to the count. An all-zero word adds nothing.
- R4: During a run, the pass flag in the cycle after a compared word is 0 if that word had a set bit and 1 otherwise. This is a one-cycle registered live indication.
- R5: A word presented with valid=0 is neither compared nor counted, whatever its content.
- R6: While lock=0 during a run, the count holds and the pass flag shows 1. When lock returns, counting resumes from the held value.
- R7: The count is 8 bits wide and saturates at 255.
- R8: In the cycle after self-test is disabled, the pass flag becomes 1 if no corrupted word was counted during the run and 0 otherwise. The flag and the count then hold unchanged while self-test stays off, whatever words arrive.
- R9: The clear input zeroes the count one cycle later when self-test is off, and leaves the pass flag unchanged. While self-test is on, the clear input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_en | input | 1 | Self-test enable for the receive side |
| lock | input | 1 | Receiver locked to the serial stream |
| word_vld | input | 1 | Recovered word valid strobe |
| word | input | DATA_W | Recovered parallel word |
| cnt_clr | input | 1 | Clear of the error count |
| pass_o | output | 1 | Pass flag: live during a run, held verdict afterwards |
| err_cnt | output | CNT_W | Saturating count of corrupted words |

## Verification
The bench sends several input patterns and checks a different property with each:
- Runs of all-zero words confirm that a clean stream leaves the count at 0 and the flag at 1.
- Words with only the LSB set and only the MSB set confirm that every bit position is compared.
- Interleaved error and clean words show that the live flag drops for exactly one cycle per corrupted word.
- Nonzero words with the strobe low, with lock low, in the entry cycle, or in normal mode show that each gating condition blocks comparison on its own.
- A long burst of errors reaches saturation.
- One clean run and one failing run confirm that the held verdict depends only on what the run counted.

// File: rtl/bist_chk_pkg.sv
package bist_chk_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Per-cycle events derived from the self-test enable
    typedef struct packed {
        logic entry;   // first cycle with enable seen high
        logic leave;   // first cycle with enable seen low after a run
        logic run;     // comparison window (after entry, enable high)
        logic idle;    // enable low: normal operation
    } phase_ev_t;

    // A word fails the all-zero pattern if any bit is set
    function automatic logic word_bad(input logic [63:0] w);
        return |w;
    endfunction

endpackage

// File: rtl/bist_phase_ctl.sv
module bist_phase_ctl
    import bist_chk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      test_en,
    output phase_ev_t ev
);
    phase_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= test_en ? PH_RUN : PH_IDLE;
    end

    always_comb begin
        ev.entry = test_en  && (phase_q == PH_IDLE);
        ev.leave = !test_en && (phase_q == PH_RUN);
        ev.run   = test_en  && (phase_q == PH_RUN);
        ev.idle  = !test_en;
    end
endmodule

// File: rtl/bist_word_cmp.sv
module bist_word_cmp
    import bist_chk_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              run,
    input  logic              lock,
    input  logic              vld,
    input  logic [DATA_W-1:0] word,
    output logic              hit
);
    localparam int PAD_W = 64 - DATA_W;

    logic [63:0] wide;

    generate
        if (PAD_W > 0) begin : g_pad
            assign wide = {{PAD_W{1'b0}}, word};
        end else begin : g_nopad
            assign wide = word[63:0];
        end
    endgenerate

    assign hit = run && lock && vld && word_bad(wide);
endmodule

// File: rtl/bist_err_cnt.sv
module bist_err_cnt
    import bist_chk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_ev_t        ev,
    input  logic             hit,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             any_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            any_err <= 1'b0;
        end else if (ev.entry) begin
            cnt     <= '0;
            any_err <= 1'b0;
        end else if (ev.run) begin
            if (hit) begin
                any_err <= 1'b1;
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end else if (ev.idle && clr) begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/bist_pass_gen.sv
module bist_pass_gen
    import bist_chk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  phase_ev_t ev,
    input  logic      hit,
    input  logic      any_err,
    output logic      pass
);
    always_ff @(posedge clk) begin
        if (rst)           pass <= 1'b1;
        else if (ev.entry) pass <= 1'b1;
        else if (ev.run)   pass <= !hit;
        else if (ev.leave) pass <= !any_err;
    end
endmodule

// File: rtl/bist_pattern_chk.sv
module bist_pattern_chk
    import bist_chk_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en,
    input  logic              lock,
    input  logic              word_vld,
    input  logic [DATA_W-1:0] word,
    input  logic              cnt_clr,
    output logic              pass_o,
    output logic [CNT_W-1:0]  err_cnt
);
    phase_ev_t ev;
    logic      hit;
    logic      any_err;

    bist_phase_ctl u_phase (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .ev      (ev)
    );

    bist_word_cmp #(.DATA_W(DATA_W)) u_cmp (
        .run  (ev.run),
        .lock (lock),
        .vld  (word_vld),
        .word (word),
        .hit  (hit)
    );

    bist_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .hit     (hit),
        .clr     (cnt_clr),
        .cnt     (err_cnt),
        .any_err (any_err)
    );

    bist_pass_gen u_pass (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .hit     (hit),
        .any_err (any_err),
        .pass    (pass_o)
    );
endmodule

// File: rtl/bist_pattern_chk_sva.sv
module bist_pattern_chk_sva #(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              test_en,
    input logic              lock,
    input logic              word_vld,
    input logic [DATA_W-1:0] word,
    input logic              cnt_clr,
    input logic              pass_o,
    input logic [CNT_W-1:0]  err_cnt
);
    logic en_q;
    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= test_en;
    end

    wire in_run  = test_en && en_q;
    wire bad_cmp = in_run && lock && word_vld && (word != '0);

    // R2
    entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (test_en && !en_q) |=> (err_cnt == '0 && pass_o));

    // R4
    live_low_chk: assert property (@(posedge clk) disable iff (rst)
        bad_cmp |=> !pass_o);

    // R4
    live_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && !bad_cmp) |=> pass_o);

    // R6
    lock_pause_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && !lock) |=> $stable(err_cnt));

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && err_cnt == {CNT_W{1'b1}}) |=> err_cnt == {CNT_W{1'b1}});

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_en && !en_q && !cnt_clr) |=> ($stable(err_cnt) && $stable(pass_o)));

    // R9
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_en && cnt_clr) |=> (err_cnt == '0));
endmodule

bind bist_pattern_chk bist_pattern_chk_sva #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .lock     (lock),
    .word_vld (word_vld),
    .word     (word),
    .cnt_clr  (cnt_clr),
    .pass_o   (pass_o),
    .err_cnt  (err_cnt)
);

// File: tb/tb_bist_pattern_chk.sv
module tb_bist_pattern_chk;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst;
    logic         test_en, lock, word_vld, cnt_clr;
    logic [W-1:0] word;
    logic         pass_o;
    logic [7:0]   err_cnt;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bist_pattern_chk #(.DATA_W(W), .CNT_W(8)) dut (
        .clk(clk), .rst(rst), .test_en(test_en), .lock(lock),
        .word_vld(word_vld), .word(word), .cnt_clr(cnt_clr),
        .pass_o(pass_o), .err_cnt(err_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at negedge, let a posedge pass, return at negedge
    task automatic step(input logic en, input logic lk, input logic v,
                        input logic [W-1:0] w, input logic c);
        test_en = en; lock = lk; word_vld = v; word = w; cnt_clr = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_errs(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 1, 24'h000100, 0);
    endtask

    task automatic t_reset;
        chk("R1 pass", pass_o, 1);
        chk("R1 cnt", err_cnt, 0);
    endtask

    task automatic t_entry;
        step(1, 1, 1, 24'h000000, 0);          // entry
        run_errs(3);
        step(0, 1, 1, 24'h000000, 0);          // leave
        chk("R8 verdict fail", pass_o, 0);
        chk("R8 count frozen", err_cnt, 3);
        step(1, 1, 1, 24'hFFFFFF, 0);          // entry with a bad word
        chk("R2 cnt cleared", err_cnt, 0);
        chk("R2 pass set", pass_o, 1);
        step(1, 1, 1, 24'h000000, 0);
        chk("R2 entry word ignored", err_cnt, 0);
    endtask

    task automatic t_live;                     // still in run
        step(1, 1, 1, 24'h000000, 0);
        chk("R3 zero word", err_cnt, 0);
        chk("R4 high on clean", pass_o, 1);
        step(1, 1, 1, 24'h000001, 0);
        chk("R3 LSB counted", err_cnt, 1);
        chk("R4 low on error", pass_o, 0);
        step(1, 1, 1, 24'h000000, 0);
        chk("R4 back high", pass_o, 1);
        step(1, 1, 1, 24'h800000, 0);
        chk("R3 MSB counted", err_cnt, 2);
        chk("R4 low on MSB", pass_o, 0);
    endtask

    task automatic t_gating;                   // still in run, cnt=2
        step(1, 1, 0, 24'hABCDEF, 0);
        chk("R5 invalid ignored cnt", err_cnt, 2);
        chk("R5 invalid ignored pass", pass_o, 1);
        step(1, 0, 1, 24'h00F000, 0);
        step(1, 0, 1, 24'h00F000, 0);
        chk("R6 unlocked hold", err_cnt, 2);
        chk("R6 unlocked pass", pass_o, 1);
        step(1, 1, 1, 24'h00F000, 0);
        chk("R6 resume", err_cnt, 3);
        step(1, 1, 1, 24'h000000, 1);
        chk("R9 clr ignored in run", err_cnt, 3);
    endtask

    task automatic t_idle;                     // leave with errors
        step(0, 1, 1, 24'h000000, 0);
        chk("R8 fail verdict", pass_o, 0);
        step(0, 1, 1, 24'h0F0F0F, 0);
        step(0, 1, 1, 24'h000000, 0);
        chk("R8 held pass", pass_o, 0);
        chk("R8 held cnt", err_cnt, 3);
        step(0, 1, 0, 24'h000000, 1);
        chk("R9 idle clr cnt", err_cnt, 0);
        chk("R9 idle clr pass", pass_o, 0);
    endtask

    task automatic t_clean_run;
        step(1, 1, 1, 24'h000000, 0);
        for (int i = 0; i < 10; i++) step(1, 1, 1, 24'h000000, 0);
        step(0, 1, 1, 24'h000000, 0);
        chk("R8 pass verdict", pass_o, 1);
        chk("R8 clean cnt", err_cnt, 0);
        step(0, 1, 1, 24'h123456, 0);
        chk("R8 hold pass", pass_o, 1);
    endtask

    task automatic t_sat;
        step(1, 1, 1, 24'h000000, 0);
        run_errs(254);
        chk("R7 at 254", err_cnt, 254);
        run_errs(1);
        chk("R7 at 255", err_cnt, 255);
        run_errs(45);
        chk("R7 saturate", err_cnt, 255);
        step(0, 1, 1, 24'h000000, 0);
        chk("R8 sat verdict", pass_o, 0);
    endtask

    initial begin
        rst = 1'b1; test_en = 0; lock = 0; word_vld = 0; word = '0; cnt_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_entry();
        t_live();
        t_gating();
        t_idle();
        t_clean_run();
        t_sat();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule